// File: doc/BRIEF.md
# CPU Interrupt Pin Controller

This block sits between a processor core and seven of its control input pins. Each pin is brought into the core clock domain, compared with the level last accepted for it, and turned into an action only when that level really changes. A repeated level is ignored. An accepted change becomes one of three things: a bit in a pending-interrupt vector, a change of time-base run state, or a core control action.

The pins are a time-base enable, an external interrupt, a system-management interrupt, a machine-check pin, an active-low checkstop, an active-low hard reset and a soft reset. Each has its own sensitivity. The time-base enable, external, system-management and soft-reset pins are active-high levels. The checkstop and hard-reset pins are active-low levels. The machine-check pin reacts to a falling edge only. A combined request line is high whenever the pending vector holds any set bit. Software can clear pending bits through a clear-strobe port.

Two small state machines hold the control state. The time-base machine has two states, TB_FROZEN and TB_RUNNING. An accepted rise of the enable pin moves it from TB_FROZEN to TB_RUNNING, and an accepted fall moves it back. The core machine has two states, CORE_RUNNING and CORE_HALTED. An accepted checkstop assertion moves it from CORE_RUNNING to CORE_HALTED. Only the block reset returns it to CORE_RUNNING. A hard-reset assertion does not change either state. It produces a registered one-cycle request pulse.

Top module: `cpu_pin_ctrl`

## Requirements
- R1: Every pin passes through two synchroniser flops and then a stored-level compare, so any resulting output change appears on the third rising clock edge after the pin changes. A pin that stays at its stored level causes no output change.
- R2: `tb_run` is 1 after an accepted rise of `tb_en_i` and 0 after an accepted fall.
- R3: `pending_o[0]` follows accepted levels of `ext_irq_i`, and `pending_o[1]` follows accepted levels of `smi_i`. Each bit is set on a rise and cleared on a fall.
- R4: An accepted high-to-low change of `mchk_i` sets `pending_o[2]`. A low-to-high change leaves `pending_o` unchanged.
- R5: An accepted low level on `chkstop_n_i` drives `core_stop_o` to 1. It stays 1, even after the pin returns high, until `rst_n` is asserted.
- R6: An accepted fall of `hreset_n_i` drives `sys_reset_req_o` high for exactly one cycle. A rise of that pin gives no pulse.
- R7: `pending_o[3]` is set by an accepted rise of `sreset_i` and cleared by an accepted fall.
- R8: `irq_req_o` is 1 exactly when `pending_o` is non-zero, in the same cycle.
- R9: A 1 on bit i of `pend_clr_i` clears `pending_o[i]` at the next edge. A set event for the same bit in that same cycle wins. A bit cleared this way stays 0 while its pin holds its level.
- R10: Reset gives `pending_o`=0, `irq_req_o`=0, `tb_run_o`=0, `core_stop_o`=0 and `sys_reset_req_o`=0. The stored and synchronised levels reset to the idle pattern: `mchk_i`, `chkstop_n_i` and `hreset_n_i` high, all other pins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tb_en_i | input | 1 | time-base enable, active high |
| ext_irq_i | input | 1 | external interrupt, active high |
| smi_i | input | 1 | system-management interrupt, active high |
| mchk_i | input | 1 | machine-check pin, falling-edge sensitive |
| chkstop_n_i | input | 1 | checkstop, active low |
| hreset_n_i | input | 1 | hard reset, active low |
| sreset_i | input | 1 | soft reset level |
| pend_clr_i | input | 4 | per-bit pending clear strobe |
| pending_o | output | 4 | pending vector: 0 ext, 1 smi, 2 machine check, 3 soft reset |
| irq_req_o | output | 1 | combined interrupt request |
| tb_run_o | output | 1 | time base running (1) or frozen (0) |
| core_stop_o | output | 1 | core halted by checkstop |
| sys_reset_req_o | output | 1 | one-cycle system reset request |

## Verification
Every pin-driven result is due on the third rising edge after the pin changes. A clear strobe acts on the first edge. The reset request pulse lasts exactly one cycle. The bench drives pins on a falling edge and counts three rising edges before it samples on the next falling edge. For latency it also samples once after only two edges, when nothing may have moved yet. The pulse is checked on two successive falling edges. Clear strobes are held for one edge and sampled on the falling edge that follows.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
    localparam int NUM_PINS = 7;
    localparam int PIN_TBEN  = 0;
    localparam int PIN_EXT   = 1;
    localparam int PIN_SMI   = 2;
    localparam int PIN_MCHK  = 3;
    localparam int PIN_CSTOP = 4;
    localparam int PIN_HRST  = 5;
    localparam int PIN_SRST  = 6;
    // resting levels: machine check, checkstop and hard reset idle high
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b0111000;

    localparam int PEND_W   = 4;
    localparam int PND_EXT  = 0;
    localparam int PND_SMI  = 1;
    localparam int PND_MCHK = 2;
    localparam int PND_SRST = 3;

    typedef enum logic {TB_FROZEN, TB_RUNNING} tb_state_e;
    typedef enum logic {CORE_RUNNING, CORE_HALTED} core_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int N      = 7,
    parameter int STAGES = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE[p]}};
            else        chain <= {chain[STAGES-2:0], pin_i[p]};
        end
        assign lvl_o[p] = chain[STAGES-1];
    end
endmodule

// File: rtl/pin_edge_track.sv
module pin_edge_track #(
    parameter int N = 7,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] stored;

    // a stored level only moves when the synchronised level differs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stored <= IDLE;
        else        stored <= lvl_i;
    end

    assign rise_o =  lvl_i & ~stored;
    assign fall_o = ~lvl_i &  stored;
endmodule

// File: rtl/pend_vector.sv
module pend_vector #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] hw_clr_i,
    input  logic [W-1:0] sw_clr_i,
    output logic [W-1:0] pending_o,
    output logic         irq_o
);
    logic [W-1:0] nxt;

    // set beats either kind of clear
    assign nxt = (pending_o & ~hw_clr_i & ~sw_clr_i) | set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_o <= '0;
            irq_o     <= 1'b0;
        end else begin
            pending_o <= nxt;
            irq_o     <= |nxt;
        end
    end
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
    import pin_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tb_rise_i,
    input  logic tb_fall_i,
    input  logic cstop_assert_i,
    input  logic hrst_assert_i,
    output logic tb_run_o,
    output logic core_stop_o,
    output logic sys_reset_req_o
);
    tb_state_e   tb_q, tb_d;
    core_state_e core_q, core_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q   <= TB_FROZEN;
            core_q <= CORE_RUNNING;
        end else begin
            tb_q   <= tb_d;
            core_q <= core_d;
        end
    end

    always_comb begin
        tb_d = tb_q;
        unique case (tb_q)
            TB_FROZEN:  if (tb_rise_i) tb_d = TB_RUNNING;
            TB_RUNNING: if (tb_fall_i) tb_d = TB_FROZEN;
            default:    tb_d = TB_FROZEN;
        endcase
    end

    always_comb begin
        core_d = core_q;
        unique case (core_q)
            CORE_RUNNING: if (cstop_assert_i) core_d = CORE_HALTED;
            CORE_HALTED:  core_d = CORE_HALTED;
            default:      core_d = CORE_RUNNING;
        endcase
    end

    always_comb begin
        tb_run_o    = (tb_q == TB_RUNNING);
        core_stop_o = (core_q == CORE_HALTED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_reset_req_o <= 1'b0;
        else        sys_reset_req_o <= hrst_assert_i;
    end
endmodule

// File: rtl/cpu_pin_ctrl.sv
module cpu_pin_ctrl
    import pin_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_en_i,
    input  logic              ext_irq_i,
    input  logic              smi_i,
    input  logic              mchk_i,
    input  logic              chkstop_n_i,
    input  logic              hreset_n_i,
    input  logic              sreset_i,
    input  logic [PEND_W-1:0] pend_clr_i,
    output logic [PEND_W-1:0] pending_o,
    output logic              irq_req_o,
    output logic              tb_run_o,
    output logic              core_stop_o,
    output logic              sys_reset_req_o
);
    logic [NUM_PINS-1:0] pins, lvl, rise, fall;
    logic [PEND_W-1:0]   set_v, hclr_v;
    logic                tb_lvl, mchk_lvl;

    assign pins[PIN_TBEN]  = tb_en_i;
    assign pins[PIN_EXT]   = ext_irq_i;
    assign pins[PIN_SMI]   = smi_i;
    assign pins[PIN_MCHK]  = mchk_i;
    assign pins[PIN_CSTOP] = chkstop_n_i;
    assign pins[PIN_HRST]  = hreset_n_i;
    assign pins[PIN_SRST]  = sreset_i;

    pin_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl));

    pin_edge_track #(.N(NUM_PINS), .IDLE(PIN_IDLE)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise), .fall_o(fall));

    // level pins set on rise, clear on fall; machine check sets on fall only
    assign set_v[PND_EXT]   = rise[PIN_EXT];
    assign hclr_v[PND_EXT]  = fall[PIN_EXT];
    assign set_v[PND_SMI]   = rise[PIN_SMI];
    assign hclr_v[PND_SMI]  = fall[PIN_SMI];
    assign set_v[PND_MCHK]  = fall[PIN_MCHK];
    assign hclr_v[PND_MCHK] = 1'b0;
    assign set_v[PND_SRST]  = rise[PIN_SRST];
    assign hclr_v[PND_SRST] = fall[PIN_SRST];

    pend_vector #(.W(PEND_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .hw_clr_i(hclr_v),
        .sw_clr_i(pend_clr_i), .pending_o(pending_o), .irq_o(irq_req_o));

    core_ctrl u_core (
        .clk(clk), .rst_n(rst_n),
        .tb_rise_i(rise[PIN_TBEN]), .tb_fall_i(fall[PIN_TBEN]),
        .cstop_assert_i(fall[PIN_CSTOP]), .hrst_assert_i(fall[PIN_HRST]),
        .tb_run_o(tb_run_o), .core_stop_o(core_stop_o),
        .sys_reset_req_o(sys_reset_req_o));

    assign tb_lvl   = lvl[PIN_TBEN];
    assign mchk_lvl = lvl[PIN_MCHK];
endmodule

// File: rtl/cpu_pin_ctrl_checker.sv
module cpu_pin_ctrl_checker
    import pin_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] pending,
    input logic              irq_req,
    input logic              tb_run,
    input logic              core_stop,
    input logic              sys_reset_req,
    input logic              tb_lvl,
    input logic              mchk_lvl
);
    assert_tb_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tb_run) |-> ($past(tb_lvl) == tb_run));

    assert_mchk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending[PND_MCHK]) |-> $past(!mchk_lvl));

    assert_stop_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_stop |=> core_stop);

    assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    assert_irq_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (pending != '0));
endmodule

bind cpu_pin_ctrl cpu_pin_ctrl_checker u_checker (
    .clk(clk), .rst_n(rst_n), .pending(pending_o), .irq_req(irq_req_o),
    .tb_run(tb_run_o), .core_stop(core_stop_o),
    .sys_reset_req(sys_reset_req_o), .tb_lvl(tb_lvl), .mchk_lvl(mchk_lvl));

// File: tb/cpu_pin_ctrl_bench.sv
module cpu_pin_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_en = 1'b0, ext_irq = 1'b0, smi = 1'b0, mchk = 1'b1;
    logic chkstop_n = 1'b1, hreset_n = 1'b1, sreset = 1'b0;
    logic [3:0] pend_clr = 4'b0;
    logic [3:0] pending;
    logic irq_req, tb_run, core_stop, sys_reset_req;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_pin_ctrl u_cpu_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .tb_en_i(tb_en), .ext_irq_i(ext_irq),
        .smi_i(smi), .mchk_i(mchk), .chkstop_n_i(chkstop_n),
        .hreset_n_i(hreset_n), .sreset_i(sreset), .pend_clr_i(pend_clr),
        .pending_o(pending), .irq_req_o(irq_req), .tb_run_o(tb_run),
        .core_stop_o(core_stop), .sys_reset_req_o(sys_reset_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // three rising edges, then sample point on the following falling edge
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 pending", pending, 0);
        chk("R10 irq", irq_req, 0);
        chk("R10 tb_run", tb_run, 0);
        chk("R10 core_stop", core_stop, 0);
        chk("R10 reset_req", sys_reset_req, 0);
    endtask

    task automatic t_tbase();
        tb_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 not yet", tb_run, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 run", tb_run, 1);
        tb_en = 1'b0;
        settle();
        chk("R2 freeze", tb_run, 0);
    endtask

    task automatic t_ext_smi();
        ext_irq = 1'b1; settle();
        chk("R3 ext set", pending, 4'b0001);
        chk("R8 irq up", irq_req, 1);
        smi = 1'b1; settle();
        chk("R3 smi set", pending, 4'b0011);
        ext_irq = 1'b0; settle();
        chk("R3 ext clr", pending, 4'b0010);
        smi = 1'b0; settle();
        chk("R3 smi clr", pending, 4'b0000);
        chk("R8 irq down", irq_req, 0);
    endtask

    task automatic t_mchk();
        mchk = 1'b0; settle();
        chk("R4 fall sets", pending, 4'b0100);
        mchk = 1'b1; settle();
        chk("R4 rise no effect", pending, 4'b0100);
        pend_clr = 4'b0100;
        @(posedge clk); @(negedge clk);
        pend_clr = 4'b0;
        chk("R9 sw clear", pending, 4'b0000);
        chk("R8 irq after clear", irq_req, 0);
    endtask

    task automatic t_clear_level();
        ext_irq = 1'b1; settle();
        chk("R3 ext set again", pending, 4'b0001);
        pend_clr = 4'b0001;
        @(posedge clk); @(negedge clk);
        pend_clr = 4'b0;
        chk("R9 clear level bit", pending, 4'b0000);
        idle(6);
        chk("R1 R9 held level no event", pending, 4'b0000);
        ext_irq = 1'b0; settle();
        chk("R3 fall keeps clear", pending, 4'b0000);
    endtask

    task automatic t_set_wins();
        ext_irq = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        pend_clr = 4'b0001;
        @(posedge clk); @(negedge clk);
        pend_clr = 4'b0;
        chk("R9 set wins", pending, 4'b0001);
        ext_irq = 1'b0; settle();
        chk("R3 cleared", pending, 4'b0000);
    endtask

    task automatic t_sreset();
        sreset = 1'b1; settle();
        chk("R7 set", pending, 4'b1000);
        sreset = 1'b0; settle();
        chk("R7 clear", pending, 4'b0000);
    endtask

    task automatic t_hreset();
        hreset_n = 1'b0; settle();
        chk("R6 pulse", sys_reset_req, 1);
        @(negedge clk);
        chk("R6 one cycle", sys_reset_req, 0);
        hreset_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6 no pulse on release", sys_reset_req, 0);
        end
    endtask

    task automatic t_cstop();
        chkstop_n = 1'b0; settle();
        chk("R5 halted", core_stop, 1);
        chkstop_n = 1'b1; idle(6);
        chk("R5 sticky", core_stop, 1);
        rst_n = 1'b0; idle(2);
        chk("R5 R10 reset restarts", core_stop, 0);
        rst_n = 1'b1; idle(5);
        chk("R5 stays running", core_stop, 0);
        chk("R10 pending after reset", pending, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_tbase();
        t_ext_smi();
        t_mchk();
        t_clear_level();
        t_set_wins();
        t_sreset();
        t_hreset();
        t_cstop();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule